// File: doc/BRIEF.md
# Paged Monitor Register Window

This block gives a host a 256-byte, byte-wide register space for a hardware-monitor function. A small set of fixed registers sits at the low offsets and a single byte at the top of the space. The upper range, from 0x10 to 0xFE, is a window onto one of sixteen internal storage pages. A page-select register at offset 0xFF picks the page that the window shows. The choice takes effect on the very next access.

Host updates go through a session. The host clears a write-enable bit in the control register at offset 0x04, which opens the session and unlocks the window. It then writes window bytes on any number of pages. Finally it sets the bit again. That 0-to-1 step sends a one-cycle change notification to the internal consumer logic. The block also keeps a mask of the pages touched during the session, so the consumer knows what to reload. Reads are always allowed and have no side effects.

Internal logic reads the same storage through its own combinational port, addressed by page and offset. One byte is also brought out as a dedicated output: the power-supply fan duty value at page 1, offset 0x98.

Top module: `hwmon_paged_regs`

## Requirements
- R1: After reset the control register reads 0x01 (locked), the page-select register reads 0x00, every window byte on every page reads 0x00, the change notification is low and the touched-page mask is zero.
- R2: A read of offset 0x04 returns the write-enable bit in bit 0 and zeros in bits 7:1. A write to 0x04 loads bit 0 from write-data bit 0 and ignores the other bits.
- R3: A write to offset 0xFF stores write-data bits 3:0 as the page number. A read of 0xFF returns that number in bits 3:0 with bits 7:4 zero.
- R4: While bit 0 of 0x04 is 0, a write to offset o (0x10 to 0xFE) stores the byte at window index o-0x10 of the selected page. A later read of that offset on that page returns it.
- R5: While bit 0 of 0x04 is 1, window writes are ignored and the stored byte keeps its value.
- R6: A page-select write applies to the very next window access. The sixteen pages hold separate contents.
- R7: A write of 1 to bit 0 of 0x04 while that bit is 0 drives `data_changed` high for exactly one cycle: the cycle after the write edge. A write of 1 while the bit is already 1, or any write of 0, gives no pulse.
- R8: Writing 0 to bit 0 of 0x04 while it is 1 clears the touched-page mask. Each accepted window write sets mask bit n, where n is the selected page. The mask holds its value through the commit until the next session opens.
- R9: Offsets 0x00 to 0x03 and 0x05 to 0x0F read as 0x00. Writes to them change no register, window byte or mask bit.
- R10: Host read data appears on `io_rdata` the cycle after the edge that samples `io_rd`. It holds until the next read. Reads never change any state, whatever the write-enable bit is.
- R11: `int_rdata` shows, combinationally, the byte at page `int_page` and offset `int_offset` when that offset is in 0x10 to 0xFE, and 0x00 for any other offset.
- R12: `psu_fan_duty` always equals the stored byte at page 1, offset 0x98.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | Host byte offset |
| io_wdata | input | 8 | Host write data |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_rdata | output | 8 | Registered host read data |
| int_page | input | 4 | Internal read port page number |
| int_offset | input | 8 | Internal read port byte offset |
| int_rdata | output | 8 | Internal read port data, combinational |
| data_changed | output | 1 | One-cycle commit notification |
| dirty_pages | output | 16 | Pages written during the current or last session |
| psu_fan_duty | output | 8 | Power-supply fan duty byte |

## Verification
Every host-side result is due one edge after the edge that samples the strobe. This applies to a stored byte, the page number, the lock bit, the mask, the commit pulse and the registered read data. So the bench drives each strobe on a falling edge, drops it on the next falling edge, and samples the outputs at that second falling edge. The pulse is checked there as high, and one falling edge later as low again. The internal read port and the fan-duty output are combinational from stored state. The bench checks them after a short settle delay at falling edges, with no clock edge between the write and the check. The bench sweeps every offset of every page with an arithmetic pattern and compares each read against the formula.

// File: rtl/hwmon_pkg.sv
package hwmon_pkg;

    // Kind of register an offset maps to
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_CTRL = 2'd1,
        RGN_WIN  = 2'd2,
        RGN_PSEL = 2'd3
    } region_e;

    // Default offsets of the host space
    localparam logic [7:0] CTRL_OFS_DEF = 8'h04;
    localparam logic [7:0] WIN_LO_DEF   = 8'h10;
    localparam logic [7:0] WIN_HI_DEF   = 8'hFE;
    localparam logic [7:0] PSEL_OFS_DEF = 8'hFF;

    // Location of the power-supply fan duty byte
    localparam int unsigned  FAN_PAGE_DEF = 1;
    localparam logic [7:0]   FAN_OFS_DEF  = 8'h98;

endpackage

// File: rtl/hwmon_addr_decode.sv
module hwmon_addr_decode
    import hwmon_pkg::*;
#(
    parameter int unsigned           ADDR_W   = 8,
    parameter int unsigned           IDX_W    = 8,
    parameter logic [ADDR_W-1:0]     CTRL_OFS = CTRL_OFS_DEF,
    parameter logic [ADDR_W-1:0]     WIN_LO   = WIN_LO_DEF,
    parameter logic [ADDR_W-1:0]     WIN_HI   = WIN_HI_DEF,
    parameter logic [ADDR_W-1:0]     PSEL_OFS = PSEL_OFS_DEF
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  win_idx
);

    logic [ADDR_W-1:0] rel_addr;

    always_comb begin
        rel_addr = addr - WIN_LO;
        win_idx  = IDX_W'(rel_addr);
        if (addr == PSEL_OFS) begin
            region = RGN_PSEL;
        end else if (addr == CTRL_OFS) begin
            region = RGN_CTRL;
        end else if ((addr >= WIN_LO) && (addr <= WIN_HI)) begin
            region = RGN_WIN;
        end else begin
            region = RGN_NONE;
        end
    end

endmodule

// File: rtl/hwmon_page_store.sv
module hwmon_page_store #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned NUM_PAGES = 16,
    parameter int unsigned WIN_DEPTH = 239,
    parameter int unsigned N_RD      = 3,
    localparam int unsigned PAGE_W   = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
    localparam int unsigned IDX_W    = (WIN_DEPTH > 1) ? $clog2(WIN_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PAGE_W-1:0] rd_page [N_RD],
    input  logic [IDX_W-1:0]  rd_idx  [N_RD],
    output logic [DATA_W-1:0] rd_data [N_RD]
);

    // Per-page read results, one entry per read port
    logic [DATA_W-1:0] page_rd [NUM_PAGES][N_RD];

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
        logic [DATA_W-1:0] cell_d [WIN_DEPTH];
        logic [DATA_W-1:0] cell_q [WIN_DEPTH];
        logic              page_hit;

        assign page_hit = wr_en && (wr_page == PAGE_W'(p))
                          && (wr_idx < IDX_W'(WIN_DEPTH));

        always_comb begin
            cell_d = cell_q;
            if (page_hit) begin
                cell_d[wr_idx] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < WIN_DEPTH; i++) begin
                    cell_q[i] <= '0;
                end
            end else begin
                cell_q <= cell_d;
            end
        end

        for (genvar r = 0; r < N_RD; r++) begin : g_rd
            assign page_rd[p][r] = (rd_idx[r] < IDX_W'(WIN_DEPTH))
                                   ? cell_q[rd_idx[r]] : '0;
        end
    end

    // Pick the addressed page for each read port
    always_comb begin
        for (int r = 0; r < N_RD; r++) begin
            rd_data[r] = page_rd[rd_page[r]][r];
        end
    end

endmodule

// File: rtl/hwmon_session_ctl.sv
module hwmon_session_ctl
    import hwmon_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned NUM_PAGES = 16,
    localparam int unsigned PAGE_W   = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  region_e              region,
    input  logic                 ctrl_bit,
    input  logic [PAGE_W-1:0]    psel_val,
    input  logic [DATA_W-1:0]    win_rdata,
    output logic                 win_we,
    output logic                 lock,
    output logic [PAGE_W-1:0]    page,
    output logic                 changed,
    output logic [NUM_PAGES-1:0] dirty,
    output logic [DATA_W-1:0]    rdata
);

    typedef struct packed {
        logic                 lock;
        logic [PAGE_W-1:0]    page;
        logic                 changed;
        logic [NUM_PAGES-1:0] dirty;
        logic [DATA_W-1:0]    rdata;
    } sess_t;

    sess_t             s_d;
    sess_t             s_q;
    logic [DATA_W-1:0] rd_mux;

    // Host read selection from current state
    always_comb begin
        unique case (region)
            RGN_CTRL: rd_mux = DATA_W'(s_q.lock);
            RGN_PSEL: rd_mux = DATA_W'(s_q.page);
            RGN_WIN:  rd_mux = win_rdata;
            default:  rd_mux = '0;
        endcase
    end

    // Next-state computation
    always_comb begin
        s_d         = s_q;
        s_d.changed = 1'b0;
        win_we      = 1'b0;

        if (wr_en) begin
            unique case (region)
                RGN_CTRL: begin
                    s_d.lock = ctrl_bit;
                    // opening a session wipes the touched-page mask
                    if (s_q.lock && !ctrl_bit) begin
                        s_d.dirty = '0;
                    end
                    // closing a session notifies the consumer
                    if (!s_q.lock && ctrl_bit) begin
                        s_d.changed = 1'b1;
                    end
                end
                RGN_PSEL: begin
                    s_d.page = psel_val;
                end
                RGN_WIN: begin
                    if (!s_q.lock) begin
                        win_we               = 1'b1;
                        s_d.dirty[s_q.page]  = 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end

        if (rd_en) begin
            s_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.lock    <= 1'b1;
            s_q.page    <= '0;
            s_q.changed <= 1'b0;
            s_q.dirty   <= '0;
            s_q.rdata   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lock    = s_q.lock;
    assign page    = s_q.page;
    assign changed = s_q.changed;
    assign dirty   = s_q.dirty;
    assign rdata   = s_q.rdata;

endmodule

// File: rtl/hwmon_paged_regs.sv
module hwmon_paged_regs
    import hwmon_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 8,
    parameter int unsigned       DATA_W    = 8,
    parameter int unsigned       NUM_PAGES = 16,
    parameter logic [ADDR_W-1:0] CTRL_OFS  = CTRL_OFS_DEF,
    parameter logic [ADDR_W-1:0] WIN_LO    = WIN_LO_DEF,
    parameter logic [ADDR_W-1:0] WIN_HI    = WIN_HI_DEF,
    parameter logic [ADDR_W-1:0] PSEL_OFS  = PSEL_OFS_DEF,
    parameter int unsigned       FAN_PAGE  = FAN_PAGE_DEF,
    parameter logic [ADDR_W-1:0] FAN_OFS   = FAN_OFS_DEF,
    localparam int unsigned PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
    localparam int unsigned WIN_DEPTH = int'(WIN_HI) - int'(WIN_LO) + 1,
    localparam int unsigned IDX_W     = (WIN_DEPTH > 1) ? $clog2(WIN_DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic [DATA_W-1:0]    io_wdata,
    input  logic                 io_wr,
    input  logic                 io_rd,
    output logic [DATA_W-1:0]    io_rdata,
    input  logic [PAGE_W-1:0]    int_page,
    input  logic [ADDR_W-1:0]    int_offset,
    output logic [DATA_W-1:0]    int_rdata,
    output logic                 data_changed,
    output logic [NUM_PAGES-1:0] dirty_pages,
    output logic [DATA_W-1:0]    psu_fan_duty
);

    localparam int unsigned     N_RD     = 3;
    localparam int unsigned     RP_HOST  = 0;
    localparam int unsigned     RP_INT   = 1;
    localparam int unsigned     RP_FAN   = 2;
    localparam logic [ADDR_W-1:0] FAN_REL = FAN_OFS - WIN_LO;

    region_e           host_rgn;
    logic [IDX_W-1:0]  host_idx;
    region_e           int_rgn;
    logic [IDX_W-1:0]  int_idx;

    logic              win_we;
    logic              host_lock;
    logic [PAGE_W-1:0] cur_page;

    logic [PAGE_W-1:0] rd_page [N_RD];
    logic [IDX_W-1:0]  rd_idx  [N_RD];
    logic [DATA_W-1:0] rd_data [N_RD];

    // Host offset decode
    hwmon_addr_decode #(
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .CTRL_OFS (CTRL_OFS),
        .WIN_LO   (WIN_LO),
        .WIN_HI   (WIN_HI),
        .PSEL_OFS (PSEL_OFS)
    ) u_host_dec (
        .addr    (io_addr),
        .region  (host_rgn),
        .win_idx (host_idx)
    );

    // Internal read port decode
    hwmon_addr_decode #(
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .CTRL_OFS (CTRL_OFS),
        .WIN_LO   (WIN_LO),
        .WIN_HI   (WIN_HI),
        .PSEL_OFS (PSEL_OFS)
    ) u_int_dec (
        .addr    (int_offset),
        .region  (int_rgn),
        .win_idx (int_idx)
    );

    always_comb begin
        rd_page[RP_HOST] = cur_page;
        rd_idx[RP_HOST]  = host_idx;
        rd_page[RP_INT]  = int_page;
        rd_idx[RP_INT]   = int_idx;
        rd_page[RP_FAN]  = PAGE_W'(FAN_PAGE);
        rd_idx[RP_FAN]   = IDX_W'(FAN_REL);
    end

    hwmon_page_store #(
        .DATA_W    (DATA_W),
        .NUM_PAGES (NUM_PAGES),
        .WIN_DEPTH (WIN_DEPTH),
        .N_RD      (N_RD)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (win_we),
        .wr_page (cur_page),
        .wr_idx  (host_idx),
        .wr_data (io_wdata),
        .rd_page (rd_page),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    hwmon_session_ctl #(
        .DATA_W    (DATA_W),
        .NUM_PAGES (NUM_PAGES)
    ) u_sess (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (io_wr),
        .rd_en     (io_rd),
        .region    (host_rgn),
        .ctrl_bit  (io_wdata[0]),
        .psel_val  (io_wdata[PAGE_W-1:0]),
        .win_rdata (rd_data[RP_HOST]),
        .win_we    (win_we),
        .lock      (host_lock),
        .page      (cur_page),
        .changed   (data_changed),
        .dirty     (dirty_pages),
        .rdata     (io_rdata)
    );

    assign int_rdata    = (int_rgn == RGN_WIN) ? rd_data[RP_INT] : '0;
    assign psu_fan_duty = rd_data[RP_FAN];

endmodule

// File: rtl/hwmon_paged_regs_chk.sv
module hwmon_paged_regs_chk #(
    parameter int unsigned       ADDR_W    = 8,
    parameter int unsigned       DATA_W    = 8,
    parameter int unsigned       NUM_PAGES = 16,
    parameter logic [ADDR_W-1:0] CTRL_OFS  = 8'h04,
    parameter logic [ADDR_W-1:0] WIN_LO    = 8'h10,
    parameter logic [ADDR_W-1:0] PSEL_OFS  = 8'hFF,
    localparam int unsigned PAGE_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    io_addr,
    input logic [DATA_W-1:0]    io_wdata,
    input logic                 io_wr,
    input logic                 io_rd,
    input logic [DATA_W-1:0]    io_rdata,
    input logic                 data_changed,
    input logic [NUM_PAGES-1:0] dirty_pages,
    input logic [DATA_W-1:0]    psu_fan_duty,
    input logic                 host_lock
);

    logic unmapped;
    assign unmapped = (io_addr < WIN_LO) && (io_addr != CTRL_OFS);

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_changed |=> !data_changed);

    // R7
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_changed |-> $past(io_wr && (io_addr == CTRL_OFS) && io_wdata[0] && !host_lock));

    // R5
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && host_lock) |=> $stable(psu_fan_duty));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && unmapped) |=> (io_rdata == '0));

    // R3
    psel_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && (io_addr == PSEL_OFS)) |=> (io_rdata[DATA_W-1:PAGE_W] == '0));

    // R8
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && (io_addr == CTRL_OFS) && !io_wdata[0] && host_lock) |=> (dirty_pages == '0));

    // R2
    ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && (io_addr == CTRL_OFS)) |=> (io_rdata == DATA_W'($past(host_lock))));

endmodule

bind hwmon_paged_regs hwmon_paged_regs_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_PAGES (NUM_PAGES),
    .CTRL_OFS  (CTRL_OFS),
    .WIN_LO    (WIN_LO),
    .PSEL_OFS  (PSEL_OFS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_addr      (io_addr),
    .io_wdata     (io_wdata),
    .io_wr        (io_wr),
    .io_rd        (io_rd),
    .io_rdata     (io_rdata),
    .data_changed (data_changed),
    .dirty_pages  (dirty_pages),
    .psu_fan_duty (psu_fan_duty),
    .host_lock    (host_lock)
);

// File: tb/test_hwmon_paged_regs.sv
`timescale 1ns/1ps
module test_hwmon_paged_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic [3:0]  int_page = '0;
    logic [7:0]  int_offset = '0;
    logic [7:0]  int_rdata;
    logic        data_changed;
    logic [15:0] dirty_pages;
    logic [7:0]  psu_fan_duty;

    int n_chk  = 0;
    int n_fail = 0;
    logic pulse_seen;

    always #2.5 clk = ~clk;

    hwmon_paged_regs i_hwmon_paged_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .io_addr      (io_addr),
        .io_wdata     (io_wdata),
        .io_wr        (io_wr),
        .io_rd        (io_rd),
        .io_rdata     (io_rdata),
        .int_page     (int_page),
        .int_offset   (int_offset),
        .int_rdata    (int_rdata),
        .data_changed (data_changed),
        .dirty_pages  (dirty_pages),
        .psu_fan_duty (psu_fan_duty)
    );

    function automatic logic [7:0] pat(int p, int o);
        return 8'((p * 37) + (o * 5) + 3);
    endfunction

    function automatic logic [15:0] low_mask(int n);
        return 16'((32'd1 << n) - 1);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr  = a;
        io_wdata = d;
        io_wr    = 1'b1;
        @(negedge clk);
        io_wr      = 1'b0;
        pulse_seen = data_changed;
    endtask

    task automatic host_rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a;
        io_rd   = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        d     = io_rdata;
    endtask

    task automatic int_look(int p, int o, output logic [7:0] d);
        int_page   = 4'(p);
        int_offset = 8'(o);
        #1;
        d = int_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 changed", 32'(data_changed), 0);
        check("R1 dirty", 32'(dirty_pages), 0);
        check("R1 fan", 32'(psu_fan_duty), 0);
        host_rd(8'h04, v); check("R1 ctrl", 32'(v), 32'h01);
        host_rd(8'hFF, v); check("R1 psel", 32'(v), 0);
        for (int p = 0; p < 16; p++) begin
            int_look(p, 8'h10, v); check("R1 page lo", 32'(v), 0);
            int_look(p, 8'hFE, v); check("R1 page hi", 32'(v), 0);
        end

        // R5 window write while locked
        host_wr(8'h20, 8'h5A);
        host_rd(8'h20, v); check("R5 locked write", 32'(v), 0);
        check("R8 no mark when locked", 32'(dirty_pages), 0);

        // R2 open session, upper bits ignored, no pulse
        host_wr(8'h04, 8'hFE);
        check("R7 no pulse on open", 32'(pulse_seen), 0);
        host_rd(8'h04, v); check("R2 ctrl after open", 32'(v), 0);

        // R4 R3 R8 sweep over every page and offset
        for (int p = 0; p < 16; p++) begin
            host_wr(8'hFF, 8'(8'hA0 | p));
            host_rd(8'hFF, v); check("R3 psel readback", 32'(v), 32'(p));
            for (int o = 16; o <= 254; o++) begin
                host_wr(8'(o), pat(p, o));
            end
            check("R8 mask grows", 32'(dirty_pages), 32'(low_mask(p + 1)));
        end

        // R9 unmapped writes and reads
        for (int a = 0; a < 16; a++) begin
            if (a != 4) host_wr(8'(a), 8'hFF);
        end
        for (int a = 0; a < 16; a++) begin
            if (a != 4) begin
                host_rd(8'(a), v); check("R9 unmapped read", 32'(v), 0);
            end
        end
        host_rd(8'h04, v); check("R9 ctrl untouched", 32'(v), 0);
        host_rd(8'hFF, v); check("R9 psel untouched", 32'(v), 32'd15);

        // R7 commit pulse
        host_wr(8'h04, 8'h01);
        check("R7 pulse high", 32'(pulse_seen), 1);
        @(negedge clk);
        check("R7 pulse one cycle", 32'(data_changed), 0);
        check("R8 mask held", 32'(dirty_pages), 32'hFFFF);
        check("R12 fan duty", 32'(psu_fan_duty), 32'(pat(1, 8'h98)));

        // R4 R6 R10 readback of every page, page switch immediate
        for (int p = 0; p < 16; p++) begin
            host_wr(8'hFF, 8'(p));
            for (int o = 16; o <= 254; o++) begin
                host_rd(8'(o), v);
                check("R4 R6 readback", 32'(v), 32'(pat(p, o)));
            end
        end
        host_wr(8'hFF, 8'd2);
        host_rd(8'h55, v); check("R6 immediate page", 32'(v), 32'(pat(2, 8'h55)));
        @(negedge clk);
        check("R10 rdata holds", 32'(io_rdata), 32'(pat(2, 8'h55)));

        // R11 internal port sweep
        for (int p = 0; p < 16; p++) begin
            for (int o = 16; o <= 254; o++) begin
                int_look(p, o, v);
                check("R11 int port", 32'(v), 32'(pat(p, o)));
            end
            int_look(p, 8'h04, v); check("R11 int ctrl ofs", 32'(v), 0);
            int_look(p, 8'hFF, v); check("R11 int psel ofs", 32'(v), 0);
            int_look(p, 8'h0F, v); check("R11 int below", 32'(v), 0);
        end

        // R5 locked write after commit, R7 no pulse when already set
        host_wr(8'hFF, 8'd3);
        host_wr(8'h40, ~pat(3, 8'h40));
        host_rd(8'h40, v); check("R5 locked after commit", 32'(v), 32'(pat(3, 8'h40)));
        host_wr(8'h04, 8'h01);
        check("R7 no pulse when locked", 32'(pulse_seen), 0);
        check("R8 mask kept", 32'(dirty_pages), 32'hFFFF);

        // R8 new session clears mask, one page marked
        host_wr(8'h04, 8'h00);
        check("R8 mask cleared", 32'(dirty_pages), 0);
        check("R7 no pulse on zero", 32'(pulse_seen), 0);
        host_wr(8'hFF, 8'd1);
        host_wr(8'h98, 8'hC3);
        check("R12 fan follows", 32'(psu_fan_duty), 32'hC3);
        host_wr(8'h04, 8'h00);
        check("R7 no pulse zero again", 32'(pulse_seen), 0);
        check("R8 zero while open keeps mask", 32'(dirty_pages), 32'h0002);
        host_wr(8'h04, 8'h03);
        check("R7 second commit", 32'(pulse_seen), 1);
        check("R8 single page", 32'(dirty_pages), 32'h0002);
        host_rd(8'h04, v); check("R2 ctrl upper zero", 32'(v), 32'h01);

        // R10 reads leave state alone
        host_rd(8'h98, v); host_rd(8'h98, v);
        check("R10 repeat read", 32'(v), 32'hC3);
        check("R10 mask after reads", 32'(dirty_pages), 32'h0002);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule